// File: doc/BRIEF.md
# Manchester Key Frame Receiver

This block listens to an already-sliced serial line and picks out short key frames. A frame opens with a run of clock-like pulses at the bit rate. These pulses let the receiver lock on. A high level held for a full bit period follows them and acts as the start marker. After that come the Manchester-coded key bits.

Each bit is sampled once in the middle of each of its two halves. The first-half sample gives one copy of the bit. The inverted second-half sample gives a second, independent copy. The two copies are compared byte by byte, and any disagreement throws the frame away and raises a one-cycle error pulse.

A level input selects learn mode. In learn mode a clean frame overwrites the stored key. In normal mode a clean frame whose key equals the stored key produces a one-cycle match pulse. A watchdog restarts the receive logic if no frame has ended within a configurable number of cycles. The stored key survives a watchdog restart and is cleared only by the reset pin.

Top module: `man_key_rx`

## Requirements
- R1: A frame is accepted only if at least PRE_MIN consecutive edge-to-edge intervals of nominal length HALF_CYC come before the start marker. A start-marker rising edge that itself follows such an interval counts toward PRE_MIN. With PRE_MIN=8, four full preamble periods (8 counted intervals) are enough and three (6 intervals) are not. A rejected frame produces no match, learned or error pulse.
- R2: A preamble interval counts only if its length lies within HALF_CYC±25% (6 to 10 cycles for HALF_CYC=8). Any edge outside that window restarts the preamble count.
- R3: The start marker is a high level held for 1.5·HALF_CYC after the last preamble edge. Data then begins 2·HALF_CYC after that edge. Each bit b is sent as b in its first half and ~b in its second half, most significant bit first, and 8·KEY_BYTES bits make up the key.
- R4: After every 8 bits, the byte built from first-half samples is compared with the byte built from inverted second-half samples. On a mismatch, error_o pulses for one cycle, the frame is dropped, and neither match_o nor learned_o pulses for it.
- R5: With learn_i high, a clean frame stores its key and learned_o pulses for one cycle. match_o never pulses in learn mode.
- R6: With learn_i low, match_o pulses for one cycle after a clean frame only if a key has been stored and the received key equals it.
- R7: If WDOG_CYC cycles pass without a kick, wdog_rst_o pulses for one cycle and the receive logic returns to preamble search. The stored key is kept.
- R8: The watchdog is kicked whenever a frame ends, whether it ends clean or with a byte mismatch.
- R9: While rst_ni is low and right after it is released, all outputs are low and no key is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Sliced serial line (asynchronous) |
| learn_i | input | 1 | Learn-mode select |
| match_o | output | 1 | One-cycle pulse on a matching key |
| learned_o | output | 1 | One-cycle pulse when the stored key is updated |
| error_o | output | 1 | One-cycle pulse on a byte copy mismatch |
| wdog_rst_o | output | 1 | One-cycle pulse when the watchdog restarts the receiver |

## Verification
Frames are built with preamble lengths of three and four periods, which sit on either side of the acceptance count. Preamble half-periods of 5, 6, 10 and 11 cycles test both edges of the timing window. The keys used have long runs (0xAAAAAA), dense transitions (0xFFFFFF) and mixed patterns, so a timing or bit-order fault changes the outcome. In other frames a single second-half sample is forced equal to its first half, in the first byte in one case and the last byte in another, to show that the error path, not a key mismatch, rejects the frame. Learn and normal frames are interleaved, so a stale stored key, a match in learn mode, or a store from a corrupted frame each gives a different pulse count.

// File: rtl/mkr_pkg.sv
package mkr_pkg;
  typedef enum logic {
    ST_HUNT,
    ST_DATA
  } rx_state_e;
endpackage

// File: rtl/mkr_edge_timer.sv
module mkr_edge_timer #(
  parameter int HALF_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic lvl_o,
  output logic edge_o,
  output logic short_o,
  output logic long_o
);
  localparam int RUN_MAX   = 2 * HALF_CYC;
  localparam int RUN_W     = $clog2(RUN_MAX + 1) + 1;
  localparam int SHORT_LO  = HALF_CYC - HALF_CYC / 4;
  localparam int SHORT_HI  = HALF_CYC + HALF_CYC / 4;
  localparam int START_RUN = HALF_CYC + HALF_CYC / 2;

  localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0] LONG_AT  = RUN_W'(START_RUN - 1);
  localparam logic [RUN_W:0]   WIN_LO   = (RUN_W+1)'(SHORT_LO);
  localparam logic [RUN_W:0]   WIN_HI   = (RUN_W+1)'(SHORT_HI);

  logic [2:0]       sync_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W:0]   ival;

  assign lvl_o  = sync_q[1];
  assign edge_o = sync_q[1] ^ sync_q[2];
  // length of the level that just ended
  assign ival    = {1'b0, run_q} + 1'b1;
  assign short_o = edge_o && (ival >= WIN_LO) && (ival <= WIN_HI);
  assign long_o  = !edge_o && (run_q == LONG_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      run_q  <= RUN_SAT;
    end else begin
      sync_q <= {sync_q[1:0], rx_i};
      if (edge_o)              run_q <= '0;
      else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/mkr_frame_dec.sv
module mkr_frame_dec
  import mkr_pkg::*;
#(
  parameter int HALF_CYC  = 16,
  parameter int KEY_BYTES = 3,
  parameter int PRE_MIN   = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   lvl_i,
  input  logic                   edge_i,
  input  logic                   short_i,
  input  logic                   long_i,
  output logic                   done_o,
  output logic                   err_o,
  output logic [8*KEY_BYTES-1:0] key_o
);
  localparam int KEY_W = 8 * KEY_BYTES;
  localparam int HC_W  = $clog2(HALF_CYC);
  localparam int BIT_W = $clog2(KEY_W + 1);
  localparam int PRE_W = $clog2(PRE_MIN + 1);

  localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(KEY_W - 1);
  localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(PRE_MIN);

  rx_state_e        st_q;
  logic [PRE_W-1:0] pre_q;
  logic [HC_W-1:0]  hc_q;
  logic             ph_q;
  logic             a_bit_q;
  logic [BIT_W-1:0] bit_q;
  logic [7:0]       b_byte_q;
  logic [KEY_W-1:0] key_q;
  logic             done_q, err_q;

  logic [7:0] a_next, b_next;
  assign a_next = {key_q[6:0], a_bit_q};
  assign b_next = {b_byte_q[6:0], ~lvl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_HUNT;
      pre_q    <= '0;
      hc_q     <= '0;
      ph_q     <= 1'b0;
      a_bit_q  <= 1'b0;
      bit_q    <= '0;
      b_byte_q <= '0;
      key_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (clr_i) begin
        st_q  <= ST_HUNT;
        pre_q <= '0;
      end else begin
        unique case (st_q)
          ST_HUNT: begin
            if (edge_i) begin
              if (!short_i)              pre_q <= '0;
              else if (pre_q != PRE_FULL) pre_q <= pre_q + 1'b1;
            end else if (long_i) begin
              pre_q <= '0;
              if (lvl_i && pre_q == PRE_FULL) begin
                st_q  <= ST_DATA;
                hc_q  <= '0;
                ph_q  <= 1'b0;
                bit_q <= '0;
              end
            end
          end
          ST_DATA: begin
            if (hc_q != HC_LAST) begin
              hc_q <= hc_q + 1'b1;
            end else begin
              hc_q <= '0;
              ph_q <= ~ph_q;
              if (!ph_q) begin
                a_bit_q <= lvl_i;
              end else begin
                key_q    <= {key_q[KEY_W-2:0], a_bit_q};
                b_byte_q <= b_next;
                bit_q    <= bit_q + 1'b1;
                if (bit_q[2:0] == 3'd7) begin
                  if (a_next != b_next) begin
                    err_q <= 1'b1;
                    st_q  <= ST_HUNT;
                  end else if (bit_q == BIT_LAST) begin
                    done_q <= 1'b1;
                    st_q   <= ST_HUNT;
                  end
                end
              end
            end
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
  assign key_o  = key_q;
endmodule

// File: rtl/mkr_wdog.sv
module mkr_wdog #(
  parameter int WDOG_CYC = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic fire_o
);
  localparam int CNT_W = $clog2(WDOG_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WDOG_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign fire_o = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (kick_i || fire_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/man_key_rx.sv
module man_key_rx #(
  parameter int HALF_CYC  = 16,
  parameter int KEY_BYTES = 3,
  parameter int PRE_MIN   = 8,
  parameter int WDOG_CYC  = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic learn_i,
  output logic match_o,
  output logic learned_o,
  output logic error_o,
  output logic wdog_rst_o
);
  localparam int KEY_W = 8 * KEY_BYTES;

  logic             lvl, edge_seen, short_ival, long_run;
  logic             done, err, wd_fire;
  logic [KEY_W-1:0] rx_key;
  logic [KEY_W-1:0] store_q;
  logic             store_vld_q;
  logic             match_q, learned_q;

  mkr_edge_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_i),
    .lvl_o   (lvl),
    .edge_o  (edge_seen),
    .short_o (short_ival),
    .long_o  (long_run)
  );

  mkr_frame_dec #(
    .HALF_CYC (HALF_CYC),
    .KEY_BYTES(KEY_BYTES),
    .PRE_MIN  (PRE_MIN)
  ) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wd_fire),
    .lvl_i  (lvl),
    .edge_i (edge_seen),
    .short_i(short_ival),
    .long_i (long_run),
    .done_o (done),
    .err_o  (err),
    .key_o  (rx_key)
  );

  mkr_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kick_i(done || err),
    .fire_o(wd_fire)
  );

  // key store survives watchdog restarts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q     <= '0;
      store_vld_q <= 1'b0;
      match_q     <= 1'b0;
      learned_q   <= 1'b0;
    end else begin
      match_q   <= done && !learn_i && store_vld_q && (rx_key == store_q);
      learned_q <= done && learn_i;
      if (done && learn_i) begin
        store_q     <= rx_key;
        store_vld_q <= 1'b1;
      end
    end
  end

  assign match_o    = match_q;
  assign learned_o  = learned_q;
  assign error_o    = err;
  assign wdog_rst_o = wd_fire;
endmodule

// File: rtl/man_key_rx_chk.sv
module man_key_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_i,
  input logic learn_i,
  input logic match_o,
  input logic learned_o,
  input logic error_o,
  input logic wdog_rst_o
);
  p_match_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  p_learned_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    learned_o |=> !learned_o);

  p_error_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o);

  p_no_match_in_learn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> !$past(learn_i));

  p_learned_needs_learn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    learned_o |-> $past(learn_i));

  p_one_outcome_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({match_o, learned_o, error_o}));

  p_error_ends_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !match_o && !learned_o);

  p_wdog_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |=> !wdog_rst_o);
endmodule

bind man_key_rx man_key_rx_chk u_chk (.*);

// File: tb/tb_man_key_rx.sv
module tb_man_key_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WD         = 4000;
  localparam int NVEC       = 18;

  typedef struct packed {
    logic        learn;
    logic [23:0] key;
    logic [4:0]  bad;   // 31: no corruption
    logic [3:0]  pre;
    logic [4:0]  half;
    logic        m, l, e;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 24'hAAAAAA, 5'd31, 4'd10, 5'd8,  1'b0, 1'b0, 1'b0, 4'd6}, // R6 nothing stored
    '{1'b1, 24'hAAAAAA, 5'd31, 4'd10, 5'd8,  1'b0, 1'b1, 1'b0, 4'd5}, // R5 learn
    '{1'b0, 24'hAAAAAA, 5'd31, 4'd10, 5'd8,  1'b1, 1'b0, 1'b0, 4'd6}, // R6 R3 match
    '{1'b0, 24'hAAAAAB, 5'd31, 4'd10, 5'd8,  1'b0, 1'b0, 1'b0, 4'd6}, // R6 last bit differs
    '{1'b0, 24'hAAAAAA, 5'd31, 4'd3,  5'd8,  1'b0, 1'b0, 1'b0, 4'd1}, // R1 too short
    '{1'b0, 24'hAAAAAA, 5'd31, 4'd4,  5'd8,  1'b1, 1'b0, 1'b0, 4'd1}, // R1 boundary
    '{1'b0, 24'hAAAAAA, 5'd31, 4'd10, 5'd11, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 too slow
    '{1'b0, 24'hAAAAAA, 5'd31, 4'd10, 5'd10, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 upper edge
    '{1'b0, 24'hAAAAAA, 5'd31, 4'd10, 5'd6,  1'b1, 1'b0, 1'b0, 4'd2}, // R2 lower edge
    '{1'b0, 24'hAAAAAA, 5'd31, 4'd10, 5'd5,  1'b0, 1'b0, 1'b0, 4'd2}, // R2 too fast
    '{1'b0, 24'hAAAAAA, 5'd3,  4'd10, 5'd8,  1'b0, 1'b0, 1'b1, 4'd4}, // R4 first byte
    '{1'b1, 24'hAAAAAA, 5'd20, 4'd10, 5'd8,  1'b0, 1'b0, 1'b1, 4'd4}, // R4 last byte, learn
    '{1'b0, 24'hAAAAAA, 5'd31, 4'd10, 5'd8,  1'b1, 1'b0, 1'b0, 4'd4}, // R4 store unchanged
    '{1'b1, 24'h123456, 5'd31, 4'd10, 5'd8,  1'b0, 1'b1, 1'b0, 4'd5}, // R5 relearn
    '{1'b0, 24'hAAAAAA, 5'd31, 4'd10, 5'd8,  1'b0, 1'b0, 1'b0, 4'd5}, // R5 old key gone
    '{1'b0, 24'h123456, 5'd31, 4'd10, 5'd8,  1'b1, 1'b0, 1'b0, 4'd3}, // R3 mixed bits
    '{1'b1, 24'h123456, 5'd31, 4'd10, 5'd8,  1'b0, 1'b1, 1'b0, 4'd5}, // R5 no match in learn
    '{1'b0, 24'hFFFFFF, 5'd31, 4'd10, 5'd8,  1'b0, 1'b0, 1'b0, 4'd3}  // R3 dense edges
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_i = 1'b0;
  logic learn_i = 1'b0;
  logic match_o, learned_o, error_o, wdog_rst_o;

  int n_checks = 0;
  int n_errors = 0;
  int n_m = 0, n_l = 0, n_e = 0, n_w = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  man_key_rx #(
    .HALF_CYC (HALF),
    .KEY_BYTES(3),
    .PRE_MIN  (8),
    .WDOG_CYC (WD)
  ) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_i),
    .learn_i   (learn_i),
    .match_o   (match_o),
    .learned_o (learned_o),
    .error_o   (error_o),
    .wdog_rst_o(wdog_rst_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni) begin
      n_m += int'(match_o);
      n_l += int'(learned_o);
      n_e += int'(error_o);
      n_w += int'(wdog_rst_o);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rx_i = 1'b0;
    rst_ni = 1'b0;
    wait_n(3);
    rst_ni = 1'b1;
  endtask

  task automatic send_frame(input logic ln, input logic [23:0] k, input int bad,
                            input int pre, input int half);
    learn_i = ln;
    rx_i = 1'b0;
    wait_n(100);
    for (int p = 0; p < pre; p++) begin
      rx_i = 1'b1; wait_n(half);
      rx_i = 1'b0; wait_n(half);
    end
    rx_i = 1'b1;
    wait_n(2*HALF);
    for (int i = 0; i < 24; i++) begin
      logic b;
      b = k[23-i];
      rx_i = b;  wait_n(HALF);
      rx_i = (i == bad) ? b : ~b;
      wait_n(HALF);
    end
    rx_i = 1'b0;
    wait_n(60);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int m0, l0, e0, w0;
    rst_ni = 1'b0;
    wait_n(2);
    // R9 outputs low in reset
    chk("R9 reset outputs", int'({match_o, learned_o, error_o, wdog_rst_o}), 0);
    rst_ni = 1'b1;
    wait_n(2);
    chk("R9 after release", int'({match_o, learned_o, error_o, wdog_rst_o}), 0);

    for (int v = 0; v < NVEC; v++) begin
      m0 = n_m; l0 = n_l; e0 = n_e;
      send_frame(VECS[v].learn, VECS[v].key, int'(VECS[v].bad),
                 int'(VECS[v].pre), int'(VECS[v].half));
      chk($sformatf("R%0d vec%0d match", VECS[v].req, v),   n_m - m0, int'(VECS[v].m));
      chk($sformatf("R%0d vec%0d learned", VECS[v].req, v), n_l - l0, int'(VECS[v].l));
      chk($sformatf("R%0d vec%0d error", VECS[v].req, v),   n_e - e0, int'(VECS[v].e));
    end

    // R9 reset clears the stored key
    do_reset();
    m0 = n_m;
    send_frame(1'b0, 24'h123456, 31, 10, HALF);
    chk("R9 no key after reset", n_m - m0, 0);

    // R7 free-running watchdog period
    do_reset();
    w0 = n_w;
    wait_n(2*WD + WD/2);
    chk("R7 pulses while idle", n_w - w0, 2);

    // R8 frame end restarts the watchdog
    do_reset();
    w0 = n_w;
    wait_n(3000);
    send_frame(1'b0, 24'hAAAAAA, 31, 10, HALF);
    wait_n(3000);
    chk("R8 kicked by frame", n_w - w0, 0);
    wait_n(2000);
    chk("R8 fires after kick window", n_w - w0, 1);

    // R7 stored key survives a watchdog restart
    do_reset();
    l0 = n_l;
    send_frame(1'b1, 24'h5A5A5A, 31, 10, HALF);
    chk("R7 learn before timeout", n_l - l0, 1);
    w0 = n_w;
    rx_i = 1'b0;
    wait_n(WD + 200);
    chk("R7 timeout seen", n_w - w0, 1);
    m0 = n_m;
    learn_i = 1'b0;
    send_frame(1'b0, 24'h5A5A5A, 31, 10, HALF);
    chk("R7 key kept after timeout", n_m - m0, 1);

    // R4 error frame also kicks (R8)
    do_reset();
    w0 = n_w; e0 = n_e;
    wait_n(3000);
    send_frame(1'b0, 24'hAAAAAA, 3, 10, HALF);
    wait_n(3300);
    chk("R4 error seen", n_e - e0, 1);
    chk("R8 kicked by error", n_w - w0, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule